// File: doc/BRIEF.md
# Bidirectional Block DMA Transfer Engine

This engine copies a block of 32-bit words between two memory ports. One port is a PCI bus master and the other is a local SDRAM controller. A single direction bit picks which side is the source. A start strobe loads a source address, a destination address and a word count. The engine then moves one word at a time. It fetches the word from the source port into a staging register that belongs to the active direction. It then stores that staged word to the destination port. Both addresses advance by four bytes after each word and the count drops by one. The run ends when the count reaches zero.

Both ports use a plain request/acknowledge handshake. A request stays up, with a stable address, command and write data, until the port acknowledges it. The acknowledge cycle carries the read data for a fetch. At each start the engine latches the PCI bus command it will use for the run. Reads use memory-read-multiple unless a disable input is set. Writes use memory-write-and-invalidate only when five configuration and alignment conditions all hold; otherwise they use a plain memory write.

Each direction has its own sticky completion flag, which is cleared by writing 1. An interrupt output follows every flag whose enable is set.

Top module: `dma_block_engine`

## Requirements
- R1: With dir=0 (PCI to SDRAM), each word is read from the PCI port at the current source address. It is then written to the SDRAM port (sd_we=1) at the current destination address with the same data. The two ports never request in the same cycle.
- R2: With dir=1 (SDRAM to PCI), each word is read from the SDRAM port (sd_we=0) at the current source address. It is then written on the PCI port at the current destination address with the same data.
- R3: After each completed store, cur_src and cur_dst each advance by 4 and remain decreases by 1. The run stops after the store that takes remain to 0, leaving busy low.
- R4: PCI writes use command 4'hF only when all of the following hold at start: mwi_en=1, xfer_mode=1, line_words is 4, 8 or 16, source address bits [5:0] are zero, and the destination address is aligned to line_words*4 bytes. In every other case PCI writes use 4'h7.
- R5: PCI reads use command 4'hC when rd_mult_dis=0 and command 4'h6 when rd_mult_dis=1.
- R6: When a run finishes, done[0] is set for dir=0 and done[1] for dir=1, on the same clock edge at which busy falls. irq is high exactly while some done bit is set whose irq_en bit is also set.
- R7: Writing 1 to a done_clr bit clears that done bit on the next edge, and irq falls with it if no other enabled done bit is set.
- R8: A start with xfer_len_in=0 issues no access on either port and sets the done bit of the selected direction on the edge that samples the strobe.
- R9: A start strobe while busy is high has no effect on the run in progress: its direction, addresses, count and command choice stay unchanged.
- R10: After reset, busy, done, irq, pci_req and sd_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start strobe |
| dir | input | 1 | 0: PCI to SDRAM, 1: SDRAM to PCI |
| src_addr_in | input | 32 | Start source byte address |
| dst_addr_in | input | 32 | Start destination byte address |
| xfer_len_in | input | 16 | Number of words to move |
| mwi_en | input | 1 | Allows write-and-invalidate |
| line_words | input | 8 | Cache line size in 32-bit words |
| xfer_mode | input | 1 | Transfer mode bit, also needed for write-and-invalidate |
| rd_mult_dis | input | 1 | Forces plain memory read |
| irq_en | input | 2 | Interrupt enable per direction |
| done_clr | input | 2 | Write-1-to-clear for the done bits |
| busy | output | 1 | Run in progress |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current destination address |
| remain | output | 16 | Words left to move |
| done | output | 2 | Sticky completion flags per direction |
| irq | output | 1 | Interrupt request |
| pci_req | output | 1 | PCI port request |
| pci_cmd | output | 4 | PCI bus command code |
| pci_addr | output | 32 | PCI byte address |
| pci_wdata | output | 32 | PCI write data |
| pci_ack | input | 1 | PCI port acknowledge |
| pci_rdata | input | 32 | PCI read data, valid with pci_ack |
| sd_req | output | 1 | SDRAM port request |
| sd_we | output | 1 | SDRAM write (1) or read (0) |
| sd_addr | output | 32 | SDRAM byte address |
| sd_wdata | output | 32 | SDRAM write data |
| sd_ack | input | 1 | SDRAM port acknowledge |
| sd_rdata | input | 32 | SDRAM read data, valid with sd_ack |

## Verification
The assertions assume that each port acknowledges only while its own request is high, and for one cycle at a time. They also assume that start is a single-cycle pulse. Under those conditions the held-request and step properties are meaningful. The bench responders set acknowledge only on a falling edge that sees an outstanding request, and they always drop it on the next falling edge. The bench also varies the wait states from zero to two cycles. Every start is driven as a one-cycle pulse from a task.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } xfer_st_e;

    localparam logic [3:0] CMD_MEM_RD      = 4'h6;
    localparam logic [3:0] CMD_MEM_WR      = 4'h7;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
    localparam logic [3:0] CMD_MEM_WR_INV  = 4'hF;

    localparam logic DIR_PCI2SD = 1'b0;
    localparam logic DIR_SD2PCI = 1'b1;

    localparam int NUM_DIRS = 2;

endpackage

// File: rtl/dma_cmd_sel.sv
module dma_cmd_sel
    import dma_eng_pkg::*;
#(
    parameter int LSIZE_W = 8,
    parameter int NUM_LS  = 3,
    parameter int LO_W    = 6
) (
    input  logic               mwi_en,
    input  logic [LSIZE_W-1:0] line_words,
    input  logic               xfer_mode,
    input  logic               rd_mult_dis,
    input  logic [LO_W-1:0]    src_lo,
    input  logic [LO_W-1:0]    dst_lo,
    output logic [3:0]         rd_cmd,
    output logic [3:0]         wr_cmd
);

    // Line sizes 4, 8, 16 words map to 16, 32, 64 byte alignment.
    localparam int BASE_LOG = 2;

    logic [NUM_LS-1:0] ls_hit;
    logic [NUM_LS-1:0] ls_aligned;

    genvar g;
    generate
        for (g = 0; g < NUM_LS; g++) begin : g_line
            localparam int ALIGN_BITS = g + BASE_LOG + 2;
            assign ls_hit[g]     = (line_words == LSIZE_W'(4 << g));
            assign ls_aligned[g] = (dst_lo[ALIGN_BITS-1:0] == '0);
        end
    endgenerate

    logic line_ok;
    logic dst_ok;
    logic src_ok;
    logic inv_ok;

    always_comb begin
        line_ok = |ls_hit;
        dst_ok  = |(ls_hit & ls_aligned);
        src_ok  = (src_lo == '0);
        inv_ok  = mwi_en && xfer_mode && line_ok && src_ok && dst_ok;
        wr_cmd  = inv_ok ? CMD_MEM_WR_INV : CMD_MEM_WR;
        rd_cmd  = rd_mult_dis ? CMD_MEM_RD : CMD_MEM_RD_MULT;
    end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [3:0]        rd_cmd_sel,
    input  logic [3:0]        wr_cmd_sel,
    output logic              busy,
    output logic [ADDR_W-1:0] src_q_o,
    output logic [ADDR_W-1:0] dst_q_o,
    output logic [LEN_W-1:0]  len_q_o,
    output logic              fin,
    output logic              fin_dir,
    output logic              pci_req,
    output logic [3:0]        pci_cmd,
    output logic [ADDR_W-1:0] pci_addr,
    output logic [DATA_W-1:0] pci_wdata,
    input  logic              pci_ack,
    input  logic [DATA_W-1:0] pci_rdata,
    output logic              sd_req,
    output logic              sd_we,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W-1:0] sd_wdata,
    input  logic              sd_ack,
    input  logic [DATA_W-1:0] sd_rdata
);

    localparam int ADDR_STEP = DATA_W / 8;

    typedef struct packed {
        xfer_st_e          st;
        logic              dir;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic [3:0]        rcmd;
        logic [3:0]        wcmd;
        logic [DATA_W-1:0] rbuf;
        logic [DATA_W-1:0] wbuf;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic  src_ack;
    logic  dst_ack;
    logic  last_word;

    always_comb begin
        c_d       = c_q;
        fin       = 1'b0;
        fin_dir   = c_q.dir;
        src_ack   = (c_q.dir == DIR_PCI2SD) ? pci_ack : sd_ack;
        dst_ack   = (c_q.dir == DIR_PCI2SD) ? sd_ack : pci_ack;
        last_word = (c_q.len == LEN_W'(1));

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.dir  = dir;
                    c_d.src  = src_in;
                    c_d.dst  = dst_in;
                    c_d.len  = len_in;
                    c_d.rcmd = rd_cmd_sel;
                    c_d.wcmd = wr_cmd_sel;
                    if (len_in == '0) begin
                        fin     = 1'b1;
                        fin_dir = dir;
                    end else begin
                        c_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (src_ack) begin
                    if (c_q.dir == DIR_PCI2SD) begin
                        c_d.rbuf = pci_rdata;
                    end else begin
                        c_d.wbuf = sd_rdata;
                    end
                    c_d.st = ST_STORE;
                end
            end
            ST_STORE: begin
                if (dst_ack) begin
                    c_d.src = c_q.src + ADDR_W'(ADDR_STEP);
                    c_d.dst = c_q.dst + ADDR_W'(ADDR_STEP);
                    c_d.len = c_q.len - LEN_W'(1);
                    if (last_word) begin
                        c_d.st = ST_IDLE;
                        fin    = 1'b1;
                    end else begin
                        c_d.st = ST_FETCH;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, dir: 1'b0, src: '0, dst: '0, len: '0,
                     rcmd: CMD_MEM_RD_MULT, wcmd: CMD_MEM_WR,
                     rbuf: '0, wbuf: '0};
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        busy      = (c_q.st != ST_IDLE);
        src_q_o   = c_q.src;
        dst_q_o   = c_q.dst;
        len_q_o   = c_q.len;
        pci_req   = ((c_q.st == ST_FETCH) && (c_q.dir == DIR_PCI2SD)) ||
                    ((c_q.st == ST_STORE) && (c_q.dir == DIR_SD2PCI));
        sd_req    = ((c_q.st == ST_FETCH) && (c_q.dir == DIR_SD2PCI)) ||
                    ((c_q.st == ST_STORE) && (c_q.dir == DIR_PCI2SD));
        pci_cmd   = (c_q.st == ST_FETCH) ? c_q.rcmd : c_q.wcmd;
        pci_addr  = (c_q.st == ST_FETCH) ? c_q.src : c_q.dst;
        sd_addr   = (c_q.st == ST_FETCH) ? c_q.src : c_q.dst;
        sd_we     = (c_q.st == ST_STORE);
        pci_wdata = c_q.wbuf;
        sd_wdata  = c_q.rbuf;
    end

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pci_req && sd_req)); // R1

    AST_PCI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && !pci_ack) |=> (pci_req && $stable(pci_addr) && $stable(pci_cmd))); // R4

    AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_req && !sd_ack) |=> (sd_req && $stable(sd_addr) && $stable(sd_we))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_STORE && dst_ack) |=>
            (len_q_o == $past(len_q_o) - LEN_W'(1)) &&
            (src_q_o == $past(src_q_o) + ADDR_W'(ADDR_STEP))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pci_req && !sd_req)); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(c_q.dir) && $stable(c_q.wcmd) && $stable(c_q.rcmd))); // R9

endmodule

// File: rtl/dma_status.sv
module dma_status
    import dma_eng_pkg::*;
#(
    parameter int N = NUM_DIRS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fin,
    input  logic         fin_dir,
    input  logic [N-1:0] done_clr,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] done,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] done;
    } stat_s;

    stat_s s_d, s_q;
    logic [N-1:0] set_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_dir
            assign set_vec[g] = fin && (fin_dir == g[0]);
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.done = (s_q.done & ~done_clr) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign irq  = |(s_q.done & irq_en);

    AST_CLEAR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr[0] && !(fin && fin_dir == 1'b0)) |=> !done[0]); // R7

    AST_CLEAR_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr[1] && !(fin && fin_dir == 1'b1)) |=> !done[1]); // R7

    AST_SET_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (fin_dir ? done[1] : done[0])); // R6

endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 16,
    parameter int LSIZE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir,
    input  logic [ADDR_W-1:0]  src_addr_in,
    input  logic [ADDR_W-1:0]  dst_addr_in,
    input  logic [LEN_W-1:0]   xfer_len_in,
    input  logic               mwi_en,
    input  logic [LSIZE_W-1:0] line_words,
    input  logic               xfer_mode,
    input  logic               rd_mult_dis,
    input  logic [1:0]         irq_en,
    input  logic [1:0]         done_clr,
    output logic               busy,
    output logic [ADDR_W-1:0]  cur_src,
    output logic [ADDR_W-1:0]  cur_dst,
    output logic [LEN_W-1:0]   remain,
    output logic [1:0]         done,
    output logic               irq,
    output logic               pci_req,
    output logic [3:0]         pci_cmd,
    output logic [ADDR_W-1:0]  pci_addr,
    output logic [DATA_W-1:0]  pci_wdata,
    input  logic               pci_ack,
    input  logic [DATA_W-1:0]  pci_rdata,
    output logic               sd_req,
    output logic               sd_we,
    output logic [ADDR_W-1:0]  sd_addr,
    output logic [DATA_W-1:0]  sd_wdata,
    input  logic               sd_ack,
    input  logic [DATA_W-1:0]  sd_rdata
);

    localparam int LO_W = 6;

    logic [3:0] rd_cmd_sel;
    logic [3:0] wr_cmd_sel;
    logic       fin;
    logic       fin_dir;

    dma_cmd_sel #(
        .LSIZE_W (LSIZE_W),
        .NUM_LS  (3),
        .LO_W    (LO_W)
    ) u_cmd (
        .mwi_en      (mwi_en),
        .line_words  (line_words),
        .xfer_mode   (xfer_mode),
        .rd_mult_dis (rd_mult_dis),
        .src_lo      (src_addr_in[LO_W-1:0]),
        .dst_lo      (dst_addr_in[LO_W-1:0]),
        .rd_cmd      (rd_cmd_sel),
        .wr_cmd      (wr_cmd_sel)
    );

    dma_xfer_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir        (dir),
        .src_in     (src_addr_in),
        .dst_in     (dst_addr_in),
        .len_in     (xfer_len_in),
        .rd_cmd_sel (rd_cmd_sel),
        .wr_cmd_sel (wr_cmd_sel),
        .busy       (busy),
        .src_q_o    (cur_src),
        .dst_q_o    (cur_dst),
        .len_q_o    (remain),
        .fin        (fin),
        .fin_dir    (fin_dir),
        .pci_req    (pci_req),
        .pci_cmd    (pci_cmd),
        .pci_addr   (pci_addr),
        .pci_wdata  (pci_wdata),
        .pci_ack    (pci_ack),
        .pci_rdata  (pci_rdata),
        .sd_req     (sd_req),
        .sd_we      (sd_we),
        .sd_addr    (sd_addr),
        .sd_wdata   (sd_wdata),
        .sd_ack     (sd_ack),
        .sd_rdata   (sd_rdata)
    );

    dma_status #(
        .N (NUM_DIRS)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .fin_dir  (fin_dir),
        .done_clr (done_clr),
        .irq_en   (irq_en),
        .done     (done),
        .irq      (irq)
    );

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req |-> (pci_cmd == CMD_MEM_RD || pci_cmd == CMD_MEM_WR ||
                     pci_cmd == CMD_MEM_RD_MULT || pci_cmd == CMD_MEM_WR_INV)); // R4

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (|done)); // R6

endmodule

// File: tb/sim_dma_block_engine.sv
`timescale 1ns/1ps
module sim_dma_block_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [31:0] src_addr_in = '0;
    logic [31:0] dst_addr_in = '0;
    logic [15:0] xfer_len_in = '0;
    logic        mwi_en = 1'b0;
    logic [7:0]  line_words = 8'd0;
    logic        xfer_mode = 1'b0;
    logic        rd_mult_dis = 1'b0;
    logic [1:0]  irq_en = '0;
    logic [1:0]  done_clr = '0;
    logic        busy;
    logic [31:0] cur_src, cur_dst;
    logic [15:0] remain;
    logic [1:0]  done;
    logic        irq;
    logic        pci_req;
    logic [3:0]  pci_cmd;
    logic [31:0] pci_addr, pci_wdata;
    logic        pci_ack = 1'b0;
    logic [31:0] pci_rdata = '0;
    logic        sd_req, sd_we;
    logic [31:0] sd_addr, sd_wdata;
    logic        sd_ack = 1'b0;
    logic [31:0] sd_rdata = '0;

    always #2 clk = ~clk;

    dma_block_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .src_addr_in(src_addr_in), .dst_addr_in(dst_addr_in), .xfer_len_in(xfer_len_in),
        .mwi_en(mwi_en), .line_words(line_words), .xfer_mode(xfer_mode),
        .rd_mult_dis(rd_mult_dis), .irq_en(irq_en), .done_clr(done_clr),
        .busy(busy), .cur_src(cur_src), .cur_dst(cur_dst), .remain(remain),
        .done(done), .irq(irq),
        .pci_req(pci_req), .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_wdata(pci_wdata),
        .pci_ack(pci_ack), .pci_rdata(pci_rdata),
        .sd_req(sd_req), .sd_we(sd_we), .sd_addr(sd_addr), .sd_wdata(sd_wdata),
        .sd_ack(sd_ack), .sd_rdata(sd_rdata)
    );

    logic [31:0] pci_mem [0:255];
    logic [31:0] sd_mem  [0:255];
    int n_pci_rd = 0, n_pci_wr = 0, n_sd_rd = 0, n_sd_wr = 0;
    int cmd_err = 0, port_err = 0;
    logic [3:0] last_rcmd = '0, last_wcmd = '0;
    logic [3:0] exp_rcmd = 4'hC, exp_wcmd = 4'h7;
    int pci_lat = 0, sd_lat = 0;
    int pci_wait = 0, sd_wait = 0;
    int total = 0, failed = 0;
    int cycles = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (pci_req && sd_req) port_err++;
        if (pci_ack) begin
            pci_ack = 1'b0;
        end else if (pci_req) begin
            if (pci_wait < pci_lat) begin
                pci_wait++;
            end else begin
                pci_wait = 0;
                pci_ack  = 1'b1;
                if (pci_cmd == 4'h7 || pci_cmd == 4'hF) begin
                    pci_mem[pci_addr[9:2]] = pci_wdata;
                    n_pci_wr++;
                    last_wcmd = pci_cmd;
                    if (pci_cmd != exp_wcmd) cmd_err++;
                end else begin
                    pci_rdata = pci_mem[pci_addr[9:2]];
                    n_pci_rd++;
                    last_rcmd = pci_cmd;
                    if (pci_cmd != exp_rcmd) cmd_err++;
                end
            end
        end
        if (sd_ack) begin
            sd_ack = 1'b0;
        end else if (sd_req) begin
            if (sd_wait < sd_lat) begin
                sd_wait++;
            end else begin
                sd_wait = 0;
                sd_ack  = 1'b1;
                if (sd_we) begin
                    sd_mem[sd_addr[9:2]] = sd_wdata;
                    n_sd_wr++;
                end else begin
                    sd_rdata = sd_mem[sd_addr[9:2]];
                    n_sd_rd++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic d, input logic [31:0] s, input logic [31:0] t,
                               input logic [15:0] n);
        @(negedge clk);
        dir = d; src_addr_in = s; dst_addr_in = t; xfer_len_in = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int k;
        k = 0;
        while (busy && k < 2000) begin
            @(negedge clk);
            k++;
        end
        if (busy) chk({tag, " timeout"}, 32'd1, 32'd0);
    endtask

    task automatic clear_done();
        @(negedge clk);
        done_clr = 2'b11;
        @(negedge clk);
        done_clr = 2'b00;
    endtask

    task automatic t_reset();
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done", {30'd0, done}, 32'd0);
        chk("R10 irq", {31'd0, irq}, 32'd0);
        chk("R10 reqs", {30'd0, pci_req, sd_req}, 32'd0);
    endtask

    task automatic t_pci_to_sd();
        for (int i = 0; i < 4; i++) pci_mem[64 + i] = 32'hA000_0000 + i * 32'h111;
        irq_en = 2'b10; rd_mult_dis = 1'b0; exp_rcmd = 4'hC;
        pci_lat = 1; sd_lat = 0;
        n_pci_rd = 0; n_sd_wr = 0;
        pulse_start(1'b0, 32'h100, 32'h040, 16'd4);
        wait_idle("R1");
        for (int i = 0; i < 4; i++)
            chk("R1 sdram data", sd_mem[16 + i], 32'hA000_0000 + i * 32'h111);
        chk("R1 pci reads", n_pci_rd, 4);
        chk("R1 sdram writes", n_sd_wr, 4);
        chk("R3 src end", cur_src, 32'h110);
        chk("R3 dst end", cur_dst, 32'h050);
        chk("R3 remain", {16'd0, remain}, 32'd0);
        chk("R5 read cmd C", {28'd0, last_rcmd}, 32'hC);
        chk("R6 done lo", {30'd0, done}, 32'b01);
        chk("R6 irq gated", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_sd_to_pci_inv();
        clear_done();
        for (int i = 0; i < 3; i++) sd_mem[128 + i] = 32'h5EED_0000 + i;
        mwi_en = 1'b1; line_words = 8'd16; xfer_mode = 1'b1; irq_en = 2'b10;
        exp_wcmd = 4'hF; pci_lat = 0; sd_lat = 2;
        n_pci_wr = 0; n_sd_rd = 0;
        pulse_start(1'b1, 32'h200, 32'h0C0, 16'd3);
        wait_idle("R2");
        for (int i = 0; i < 3; i++)
            chk("R2 pci data", pci_mem[48 + i], 32'h5EED_0000 + i);
        chk("R2 sdram reads", n_sd_rd, 3);
        chk("R4 write cmd F", {28'd0, last_wcmd}, 32'hF);
        chk("R6 done hi", {30'd0, done}, 32'b10);
        chk("R6 irq", {31'd0, irq}, 32'd1);
        @(negedge clk);
        done_clr = 2'b10;
        @(negedge clk);
        done_clr = 2'b00;
        chk("R7 done cleared", {30'd0, done}, 32'd0);
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_inv_conditions();
        logic [3:0] exp;
        for (int k = 0; k < 7; k++) begin
            logic [31:0] s, t;
            mwi_en = 1'b1; line_words = 8'd8; xfer_mode = 1'b1;
            s = 32'h240; t = 32'h0A0; exp = 4'hF;
            case (k)
                1: begin mwi_en = 1'b0; exp = 4'h7; end
                2: begin line_words = 8'd12; exp = 4'h7; end
                3: begin s = 32'h244; exp = 4'h7; end
                4: begin t = 32'h0B0; exp = 4'h7; end
                5: begin xfer_mode = 1'b0; exp = 4'h7; end
                6: begin line_words = 8'd4; t = 32'h0B0; exp = 4'hF; end
                default: ;
            endcase
            exp_wcmd = exp;
            clear_done();
            pulse_start(1'b1, s, t, 16'd1);
            wait_idle("R4");
            chk($sformatf("R4 variant %0d cmd", k), {28'd0, last_wcmd}, {28'd0, exp});
        end
        chk("R4 no command mismatch", cmd_err, 0);
    endtask

    task automatic t_plain_read();
        clear_done();
        rd_mult_dis = 1'b1; exp_rcmd = 4'h6;
        pci_mem[10] = 32'h1234_5678; pci_mem[11] = 32'h9ABC_DEF0;
        pulse_start(1'b0, 32'h028, 32'h3F0, 16'd2);
        wait_idle("R5");
        chk("R5 read cmd 6", {28'd0, last_rcmd}, 32'h6);
        chk("R5 data", sd_mem[253], 32'h9ABC_DEF0);
        chk("R5 no command mismatch", cmd_err, 0);
        rd_mult_dis = 1'b0; exp_rcmd = 4'hC;
    endtask

    task automatic t_zero_len();
        int acc;
        clear_done();
        acc = n_pci_rd + n_pci_wr + n_sd_rd + n_sd_wr;
        @(negedge clk);
        dir = 1'b1; xfer_len_in = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 done at strobe edge", {30'd0, done}, 32'b10);
        chk("R8 not busy", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 no access", n_pci_rd + n_pci_wr + n_sd_rd + n_sd_wr, acc);
    endtask

    task automatic t_start_while_busy();
        int wr_before;
        clear_done();
        for (int i = 0; i < 4; i++) pci_mem[192 + i] = 32'hC0DE_0000 + i;
        pci_lat = 2; sd_lat = 1;
        wr_before = n_pci_wr;
        pulse_start(1'b0, 32'h300, 32'h380, 16'd4);
        repeat (3) @(negedge clk);
        pulse_start(1'b1, 32'h000, 32'h000, 16'd2);
        wait_idle("R9");
        chk("R9 done only lo", {30'd0, done}, 32'b01);
        chk("R9 no pci writes", n_pci_wr, wr_before);
        chk("R9 dst end", cur_dst, 32'h390);
        chk("R9 last word", sd_mem[227], 32'hC0DE_0003);
        chk("R1 ports exclusive", port_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            pci_mem[i] = 32'hDEAD_0000 + i;
            sd_mem[i]  = 32'hBEEF_0000 + i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pci_to_sd();
        t_sd_to_pci_inv();
        t_inv_conditions();
        t_plain_read();
        t_zero_len();
        t_start_while_busy();
        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule